// File: doc/BRIEF.md
# Multiplexed Pixel Word Unpacker

This block sits between a wide pixel port and a per-dot pixel pipeline. Once per word it latches a 32-bit word that carries one or more pixels. It then hands those pixels out, one per dot clock, in a fixed lane order. A strobe marks the last dot of each word, so the source knows when to present the next word.

An 8-bit mux-control code written through a small host port picks the packing:
- four 8-bit pixels per word,
- two 16-bit pixels per word,
- one 32-bit true-colour pixel per word, or
- pass-through, which forwards the low byte once per dot. Pass-through is also the reset state.

An order flag reverses the lane order. A new setting never breaks into a word that is already being replayed. It is applied at the next word boundary.

The block runs on the dot clock. The word interval it implies is 4, 2 or 1 dots, following the selected packing. Producing the slower load clock itself is left to the surroundings.

Top module: `pix_unpacker`

## Requirements
- R1: Code 1Eh selects 8-bit pixels, four per word. With the order flag clear, the dots show bits 7..0, 15..8, 23..16 and 31..24 in that order, each zero-extended to 32 bits on `pix_out`.
- R2: Code 1Ch selects 16-bit pixels, two per word. With the order flag clear, bits 15..0 come first and bits 31..16 second, each zero-extended.
- R3: Code 1Dh selects one 32-bit pixel per word. With the order flag clear, the whole word appears unchanged, and a new word is taken every dot.
- R4: `load_req` is high exactly during the last dot of each word. The value on `word_in` during that dot is latched at the closing clock edge, and its first pixel appears in the following dot.
- R5: Code 2Dh selects pass-through. Bits 7..0 of the latched word appear with bits 31..8 at zero, a new word is taken every dot, and the order flag has no effect.
- R6: Any code other than 1Eh, 1Ch and 1Dh behaves as pass-through.
- R7: A host write made while a word is still being replayed takes effect at the next word boundary. The current word finishes under the old setting, and if several writes land before the boundary, the last one wins.
- R8: A host write made in the same dot as `load_req` applies to the word latched at that edge.
- R9: With the order flag set, the lane order reverses: 8-bit mode shows bits 31..24 first, 16-bit mode shows bits 31..16 first, and 32-bit mode shows the word byte-swapped.
- R10: During and right after reset, the setting is pass-through with the flag clear, the latched word is zero, `pix_out` is 0 and `load_req` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the mux-control setting |
| host_code | input | 8 | Mux-control code to write |
| host_big | input | 1 | Order flag to write (1 = highest lane first) |
| word_in | input | 32 | Packed pixel word, latched at the end of a dot with `load_req` high |
| pix_out | output | 32 | Current pixel, zero-extended |
| load_req | output | 1 | High in the last dot of the current word |

## Verification
A host write can land in the same dot as a word boundary, where it collides with the latching of a new word and the promotion of any pending setting. The sweep provokes this by waiting until the dot counter sits on the last dot and then issuing the write, in every packing and both orders. It also issues writes one or two dots earlier, including back-to-back writes. A model in the bench decides which setting governs each word, and judges every dot's pixel and strobe against that decision, so a write that lands on the wrong side of the boundary shows up as a wrong lane or a wrong strobe spacing.

// File: rtl/pu_pkg.sv
package pu_pkg;

   typedef enum logic [1:0] {
      PM_PASS = 2'd0,
      PM_B8   = 2'd1,
      PM_B16  = 2'd2,
      PM_B32  = 2'd3
   } pmode_e;

   typedef struct packed {
      pmode_e mode;
      logic   big;
   } pcfg_t;

   localparam pcfg_t CFG_RESET = '{mode: PM_PASS, big: 1'b0};

   function automatic pmode_e decode_code(input logic [7:0] code,
                                          input logic [7:0] c8,
                                          input logic [7:0] c16,
                                          input logic [7:0] c32);
      if (code == c8)       return PM_B8;
      else if (code == c16) return PM_B16;
      else if (code == c32) return PM_B32;
      else                  return PM_PASS;
   endfunction

   function automatic logic [2:0] pix_per_word(input pmode_e m);
      case (m)
         PM_B8:   return 3'd4;
         PM_B16:  return 3'd2;
         default: return 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/pu_cfg_reg.sv
module pu_cfg_reg
   import pu_pkg::*;
#(
   parameter logic [7:0] CODE_B8  = 8'h1E,
   parameter logic [7:0] CODE_B16 = 8'h1C,
   parameter logic [7:0] CODE_B32 = 8'h1D
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_wr,
   input  logic [7:0] host_code,
   input  logic       host_big,
   input  logic       boundary,
   output pcfg_t      act_cfg
);

   pcfg_t wr_cfg;
   pcfg_t pend_cfg;
   logic  pend_v;

   always_comb begin
      wr_cfg.mode = decode_code(host_code, CODE_B8, CODE_B16, CODE_B32);
      wr_cfg.big  = host_big;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cfg  <= CFG_RESET;
         pend_cfg <= CFG_RESET;
         pend_v   <= 1'b0;
      end else if (boundary) begin
         pend_v <= 1'b0;
         if (host_wr)     act_cfg <= wr_cfg;
         else if (pend_v) act_cfg <= pend_cfg;
      end else if (host_wr) begin
         pend_cfg <= wr_cfg;
         pend_v   <= 1'b1;
      end
   end

endmodule

// File: rtl/pu_dot_ctr.sv
module pu_dot_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W:0]   ppw,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);

   assign last = ({1'b0, cnt} == (ppw - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (last) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pu_lane_sel.sv
module pu_lane_sel
   import pu_pkg::*;
#(
   parameter int LANE_W = 8,
   localparam int LANES  = 4,
   localparam int WORD_W = LANE_W * LANES
) (
   input  logic [WORD_W-1:0] word,
   input  logic [1:0]        cnt,
   input  pcfg_t             cfg,
   output logic [WORD_W-1:0] pix
);

   logic [LANE_W-1:0]   lane    [LANES];
   logic [2*LANE_W-1:0] half    [2];
   logic [WORD_W-1:0]   swapped;
   logic [1:0]          idx8;
   logic                idx16;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word[g*LANE_W +: LANE_W];
      assign swapped[g*LANE_W +: LANE_W] = word[(LANES-1-g)*LANE_W +: LANE_W];
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign half[h] = word[h*2*LANE_W +: 2*LANE_W];
   end

   always_comb begin
      idx8  = cfg.big ? ~cnt : cnt;
      idx16 = cfg.big ? ~cnt[0] : cnt[0];
      case (cfg.mode)
         PM_B8:   pix = WORD_W'(lane[idx8]);
         PM_B16:  pix = WORD_W'(half[idx16]);
         PM_B32:  pix = cfg.big ? swapped : word;
         default: pix = WORD_W'(lane[0]);
      endcase
   end

endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
   import pu_pkg::*;
#(
   parameter int         LANE_W    = 8,
   parameter logic [7:0] CODE_B8   = 8'h1E,
   parameter logic [7:0] CODE_B16  = 8'h1C,
   parameter logic [7:0] CODE_B32  = 8'h1D,
   parameter logic [7:0] CODE_PASS = 8'h2D,
   localparam int WORD_W = LANE_W * 4,
   localparam int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [7:0]        host_code,
   input  logic              host_big,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] pix_out,
   output logic              load_req
);

   if (LANE_W < 1) begin : g_bad_width
      $error("pix_unpacker: LANE_W must be at least 1");
   end
   if (CODE_B8 == CODE_B16 || CODE_B8 == CODE_B32 || CODE_B16 == CODE_B32 ||
       CODE_PASS == CODE_B8 || CODE_PASS == CODE_B16 || CODE_PASS == CODE_B32) begin : g_bad_codes
      $error("pix_unpacker: mux-control codes must be distinct");
   end

   pcfg_t             act_cfg;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] word_q;

   pu_cfg_reg #(
      .CODE_B8 (CODE_B8),
      .CODE_B16(CODE_B16),
      .CODE_B32(CODE_B32)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_wr  (host_wr),
      .host_code(host_code),
      .host_big (host_big),
      .boundary (load_req),
      .act_cfg  (act_cfg)
   );

   pu_dot_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .ppw  (pix_per_word(act_cfg.mode)),
      .cnt  (cnt),
      .last (load_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word_q <= '0;
      else if (load_req) word_q <= word_in;
   end

   pu_lane_sel #(.LANE_W(LANE_W)) u_sel (
      .word(word_q),
      .cnt (cnt),
      .cfg (act_cfg),
      .pix (pix_out)
   );

endmodule

// File: rtl/pu_unpacker_chk.sv
module pu_unpacker_chk
   import pu_pkg::*;
#(
   parameter int LANE_W = 8,
   localparam int WORD_W = LANE_W * 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_req,
   input logic [WORD_W-1:0] pix_out,
   input logic [WORD_W-1:0] word_in,
   input pcfg_t             act_cfg
);

   logic [3:0] gap;
   logic       seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= 4'd1;
         seen <= 1'b0;
      end else if (load_req) begin
         gap  <= 4'd1;
         seen <= 1'b1;
      end else begin
         gap <= gap + 4'd1;
      end
   end

   // R4
   word_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && seen) |-> (gap == {1'b0, pix_per_word(act_cfg.mode)}));

   // R7
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_req |=> $stable(act_cfg));

   // R1
   first_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(load_req) && act_cfg.mode == PM_B8 && !act_cfg.big)
         |-> (pix_out == WORD_W'($past(word_in[LANE_W-1:0]))));

   // R5
   pass_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cfg.mode == PM_PASS) |-> (load_req && pix_out[WORD_W-1:LANE_W] == '0));

   // R3
   true_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cfg.mode == PM_B32) |-> load_req);

endmodule

bind pix_unpacker pu_unpacker_chk #(.LANE_W(LANE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .load_req(load_req),
   .pix_out (pix_out),
   .word_in (word_in),
   .act_cfg (act_cfg)
);

// File: tb/pix_unpacker_test.sv
module pix_unpacker_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [7:0]  host_code = 8'h00;
   logic        host_big = 1'b0;
   logic [31:0] word_in = 32'h0;
   logic [31:0] pix_out;
   logic        load_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state: 0 pass, 1 b8, 2 b16, 3 b32
   int          m_mode = 0;
   bit          m_big  = 1'b0;
   int          p_mode = 0;
   bit          p_big  = 1'b0;
   bit          p_v    = 1'b0;
   int          m_cnt  = 0;
   logic [31:0] m_word = 32'h0;
   int          widx   = 0;
   int          cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pix_unpacker uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_code(host_code),
      .host_big(host_big), .word_in(word_in), .pix_out(pix_out), .load_req(load_req)
   );

   function automatic int code_mode(input logic [7:0] c);
      if (c == 8'h1E) return 1;
      if (c == 8'h1C) return 2;
      if (c == 8'h1D) return 3;
      return 0;
   endfunction

   function automatic int ppw(input int m);
      return (m == 1) ? 4 : (m == 2) ? 2 : 1;
   endfunction

   function automatic logic [31:0] gen_word(input int k);
      logic [31:0] v;
      v = 32'h9E3779B9 * (k + 1);
      return v ^ {k[7:0], ~k[7:0], k[7:0] + 8'h11, 8'h5A};
   endfunction

   function automatic logic [31:0] exp_pix(input int m, input bit big,
                                            input logic [31:0] w, input int c);
      int l;
      case (m)
         1: begin l = big ? 3 - c : c; return (w >> (8*l)) & 32'hFF; end
         2: begin l = big ? 1 - c : c; return (w >> (16*l)) & 32'hFFFF; end
         3: return big ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
         default: return w & 32'hFF;
      endcase
   endfunction

   function automatic string req_of(input int m, input bit big);
      if (big && (m == 1 || m == 2 || m == 3)) return "R9";
      case (m)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
      end
   endtask

   // one dot, entered and left at a falling edge
   task automatic dot(input bit wr, input logic [7:0] code, input bit big, input string wreq);
      bit bnd;
      bnd = (m_cnt == ppw(m_mode) - 1);
      host_wr = wr; host_code = code; host_big = big;
      word_in = bnd ? gen_word(widx) : (32'hDEAD0000 ^ cyc);
      #1;
      check(wr ? wreq : "R4", {31'b0, load_req}, {31'b0, bnd});
      check(wr ? wreq : req_of(m_mode, m_big), pix_out, exp_pix(m_mode, m_big, m_word, m_cnt));
      @(posedge clk);
      if (bnd) begin
         m_word = word_in; widx++; m_cnt = 0;
         if (wr) begin m_mode = code_mode(code); m_big = big; end
         else if (p_v) begin m_mode = p_mode; m_big = p_big; end
         p_v = 1'b0;
      end else begin
         m_cnt++;
         if (wr) begin p_mode = code_mode(code); p_big = big; p_v = 1'b1; end
      end
      @(negedge clk);
      host_wr = 1'b0;
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) dot(1'b0, 8'h00, 1'b0, "");
   endtask

   task automatic to_cnt(input int k);
      for (int i = 0; i < 8 && m_cnt != k; i++) idle(1);
   endtask

   task automatic to_last();
      for (int i = 0; i < 8 && m_cnt != ppw(m_mode) - 1; i++) idle(1);
   endtask

   initial begin
      logic [7:0] codes [4];
      codes[0] = 8'h2D; codes[1] = 8'h1E; codes[2] = 8'h1C; codes[3] = 8'h1D;
      #3;
      // R10 reset state
      check("R10", pix_out, 32'h0);
      check("R10", {31'b0, load_req}, 32'h1);
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      // sweep every code and order, written on the boundary dot (R8)
      for (int c = 0; c < 4; c++) begin
         for (int b = 0; b < 2; b++) begin
            to_last();
            dot(1'b1, codes[c], b[0], "R8");
            idle(14);
         end
      end
      // unrecognized codes fall back to pass-through (R6)
      for (int k = 0; k < 6; k++) begin
         to_last();
         dot(1'b1, 8'h1E, 1'b0, "R8");
         idle(5);
         to_last();
         dot(1'b1, 8'h40 + 8'(k * 37), k[0], "R6");
         idle(6);
      end
      // mid-word writes in 8-bit mode, including two before one boundary (R7)
      to_last();
      dot(1'b1, 8'h1E, 1'b0, "R8");
      for (int b = 0; b < 2; b++) begin
         to_cnt(1);
         dot(1'b1, 8'h1C, b[0], "R7");
         idle(6);
         to_last();
         dot(1'b1, 8'h1E, 1'b1, "R8");
         to_cnt(0);
         dot(1'b1, 8'h1D, 1'b0, "R7");
         dot(1'b1, 8'h1E, 1'b0, "R7");
         idle(10);
      end
      // mid-word write in 16-bit mode
      to_last();
      dot(1'b1, 8'h1C, 1'b1, "R8");
      to_cnt(0);
      dot(1'b1, 8'h2D, 1'b0, "R7");
      idle(6);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule